// File: doc/BRIEF.md
# Sign-Aware Normalization Shift Counter

This block looks at a mantissa word and reports how many positions it must move left so that its leading significant digit lands in the top bit. It is meant to feed the shift-amount input of a normalizing shifter, and the exponent adjust logic beside it. Both sign-magnitude and two's-complement mantissas are supported through a single sign input.

For a positive or sign-magnitude value the sign input is held low, and the search finds the highest 1 bit. For a negative two's-complement value the sign input is driven high. Every bit is then inverted before the search, so the count points at the highest 0 bit of the raw word. A word that has no significant digit at all gives the largest count, 31, the same as a word whose only significant digit is bit 0. The block is purely combinational. It has no clock and no reset, and the count follows the inputs within the same cycle.

Top module: `nlz_norm_encode`

## Requirements
- R1: When bit 31 of the conditioned word (each mantissa bit XOR the sign input) is 1, the count output is 0.
- R2: For any conditioned word that is not zero, the count equals the number of zero bits above its highest 1 bit, and bit (31 - count) of the conditioned word is 1.
- R3: With the sign input at 1, the count locates the highest 0 bit of the raw mantissa; for example 0xC000_0000 gives 2 and 0x7FFF_FFFF gives 0.
- R4: When bit 31 of the conditioned word is 0 and bit 30 is 1, the count is 1.
- R5: When bit 0 is the only 1 bit of the conditioned word, the count is 31.
- R6: When the conditioned word is all zeros (raw 0 with sign 0, or raw 0xFFFF_FFFF with sign 1), the count saturates at 31.
- R7: The count never carries an unknown value while the inputs are known.
- R8: The count is combinational: a change of the inputs between clock edges shows at the output before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mant_i | input | 32 | Mantissa word to be searched |
| sign_i | input | 1 | 1 inverts every mantissa bit before the search (negative two's-complement value) |
| shift_o | output | 5 | Left shift needed to bring the leading significant digit to bit 31, saturating at 31 |

## Verification
The bound checker re-evaluates the conditioned word on every input change. It confirms that the bit the count points at is set, that no bit above it is set, the fixed answers for a set top bit, for bit 30 as the highest set bit and for a word that is zero above bit 0, and that the count is never unknown. The bench's sweeps show what a property cannot show on its own: that the count agrees with an independent leading-zero count for every single-bit word and for random words of every leading-zero length under both sign values, that the sign input inverts the search target on realistic negative values, and that the output settles between clock edges.

// File: rtl/nlz_pkg.sv
package nlz_pkg;

    // Default mantissa width and the bit-group size used by the two-level search
    localparam int NLZ_WIDTH = 32;
    localparam int NLZ_GROUP = 4;

    // True when v is a nonzero power of two
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Largest count the encoder can report, used for the saturated case
    function automatic int max_count(input int width);
        return width - 1;
    endfunction

endpackage

// File: rtl/nlz_sign_cond.sv
module nlz_sign_cond #(
    parameter int WIDTH = nlz_pkg::NLZ_WIDTH
) (
    input  logic [WIDTH-1:0] raw_i,
    input  logic             sign_i,
    output logic [WIDTH-1:0] cond_o
);
    // Inverting a negative two's-complement word turns its leading
    // sign copies into zeros, so the same 1-search serves both forms
    assign cond_o = raw_i ^ {WIDTH{sign_i}};
endmodule

// File: rtl/nlz_group_enc.sv
module nlz_group_enc #(
    parameter int GROUP = nlz_pkg::NLZ_GROUP,
    localparam int LGW  = $clog2(GROUP)
) (
    input  logic [GROUP-1:0] bits_i,
    output logic             hit_o,
    output logic [LGW-1:0]   lz_o
);
    assign hit_o = |bits_i;

    // Walk upward so the highest set bit is the last to write
    always_comb begin
        lz_o = '0;
        for (int i = 0; i < GROUP; i++) begin
            if (bits_i[i]) begin
                lz_o = LGW'(GROUP - 1 - i);
            end
        end
    end
endmodule

// File: rtl/nlz_group_sel.sv
module nlz_group_sel #(
    parameter int WIDTH = nlz_pkg::NLZ_WIDTH,
    parameter int GROUP = nlz_pkg::NLZ_GROUP,
    localparam int NG   = WIDTH / GROUP,
    localparam int LGW  = $clog2(GROUP),
    localparam int CW   = $clog2(WIDTH)
) (
    input  logic [NG-1:0]          hit_i,
    input  logic [NG-1:0][LGW-1:0] lz_i,
    output logic [CW-1:0]          count_o
);
    localparam int SAT = nlz_pkg::max_count(WIDTH);

    // Group 0 holds the lowest bits; the highest group with a hit wins
    always_comb begin
        count_o = CW'(SAT);
        for (int g = 0; g < NG; g++) begin
            if (hit_i[g]) begin
                count_o = CW'((NG - 1 - g) * GROUP + int'(lz_i[g]));
            end
        end
    end
endmodule

// File: rtl/nlz_norm_encode.sv
module nlz_norm_encode #(
    parameter int WIDTH = nlz_pkg::NLZ_WIDTH,
    parameter int GROUP = nlz_pkg::NLZ_GROUP,
    localparam int NG   = WIDTH / GROUP,
    localparam int LGW  = $clog2(GROUP),
    localparam int CW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] mant_i,
    input  logic             sign_i,
    output logic [CW-1:0]    shift_o
);
    initial begin
        if (!nlz_pkg::is_pow2(WIDTH) || !nlz_pkg::is_pow2(GROUP) ||
            GROUP < 2 || GROUP > WIDTH) begin
            $error("nlz_norm_encode: WIDTH and GROUP must be powers of two, 2 <= GROUP <= WIDTH");
        end
    end

    logic [WIDTH-1:0]       cond_w;
    logic [NG-1:0]          hit_w;
    logic [NG-1:0][LGW-1:0] lz_w;

    nlz_sign_cond #(.WIDTH(WIDTH)) cond_i (
        .raw_i  (mant_i),
        .sign_i (sign_i),
        .cond_o (cond_w)
    );

    for (genvar g = 0; g < NG; g++) begin : g_grp
        nlz_group_enc #(.GROUP(GROUP)) enc_i (
            .bits_i (cond_w[g*GROUP +: GROUP]),
            .hit_o  (hit_w[g]),
            .lz_o   (lz_w[g])
        );
    end

    nlz_group_sel #(.WIDTH(WIDTH), .GROUP(GROUP)) sel_i (
        .hit_i   (hit_w),
        .lz_i    (lz_w),
        .count_o (shift_o)
    );
endmodule

// File: rtl/nlz_norm_encode_chk.sv
module nlz_norm_encode_chk #(
    parameter int WIDTH = nlz_pkg::NLZ_WIDTH,
    localparam int CW   = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] mant_i,
    input logic             sign_i,
    input logic [CW-1:0]    shift_o
);
    localparam int SAT = WIDTH - 1;

    logic [WIDTH-1:0] c_w;
    assign c_w = mant_i ^ {WIDTH{sign_i}};

    always_comb begin
        // R7: known inputs give a known count
        if (!$isunknown({mant_i, sign_i})) begin
            assert_known_count_R7: assert (!$isunknown(shift_o))
                else $error("R7 count unknown");
        end
        if (!$isunknown({mant_i, sign_i, shift_o})) begin
            // R1: a set top bit needs no shift
            assert_top_bit_R1: assert (!c_w[WIDTH-1] || shift_o == '0)
                else $error("R1 count %0d with top bit set", shift_o);
            // R4: bit 30 as leading digit needs one shift
            assert_second_bit_R4: assert (c_w[WIDTH-1:WIDTH-2] != 2'b01 || shift_o == CW'(1))
                else $error("R4 count %0d", shift_o);
            // R5, R6: nothing above bit 0 saturates the count
            assert_saturate_R6: assert (c_w[WIDTH-1:1] != '0 || shift_o == CW'(SAT))
                else $error("R5/R6 count %0d", shift_o);
            // R2: the selected bit is set and no higher bit is
            assert_lead_bit_R2: assert (c_w == '0 ||
                    (c_w[WIDTH-1-int'(shift_o)] &&
                     (shift_o == '0 || (c_w >> (WIDTH - int'(shift_o))) == '0)))
                else $error("R2 count %0d for word %h", shift_o, c_w);
        end
    end
endmodule

bind nlz_norm_encode nlz_norm_encode_chk #(.WIDTH(WIDTH)) chk_i (
    .mant_i  (mant_i),
    .sign_i  (sign_i),
    .shift_o (shift_o)
);

// File: tb/nlz_norm_encode_tb_top.sv
module nlz_norm_encode_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] mant = '0;
    logic         sgn = 1'b0;
    logic [4:0]   shift;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nlz_norm_encode dut_i (
        .mant_i  (mant),
        .sign_i  (sgn),
        .shift_o (shift)
    );

    // Independent leading-zero count of the conditioned word, saturating at 31
    function automatic int ref_count(input logic [W-1:0] w, input logic s);
        logic [W-1:0] c;
        c = w ^ {W{s}};
        for (int k = W - 1; k >= 0; k--) begin
            if (c[k]) return W - 1 - k;
        end
        return W - 1;
    endfunction

    task automatic expect_val(input int exp_v, input string req);
        n_checks++;
        if (int'(shift) != exp_v) begin
            n_errors++;
            $display("FAIL %s mant=%h sign=%0d actual=%0d expected=%0d",
                     req, mant, sgn, shift, exp_v);
        end
    endtask

    // Drive at the falling edge, sample 1 ns later, well before the rising edge
    task automatic apply(input logic [W-1:0] w, input logic s, input int exp_v, input string req);
        @(negedge clk);
        mant = w;
        sgn  = s;
        #1;
        expect_val(exp_v, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: zero word with sign 0 (R6)
        @(negedge clk);
        #1;
        expect_val(31, "R6 idle zero word");

        apply(32'h8000_0000, 1'b0, 0,  "R1 top bit");
        apply(32'hFFFF_FFFF, 1'b0, 0,  "R1 all ones sign0");
        apply(32'h4000_0000, 1'b0, 1,  "R4 bit30");
        apply(32'h7FFF_FFFF, 1'b0, 1,  "R4 bit30 with lower ones");
        apply(32'h0000_0001, 1'b0, 31, "R5 bit0 only");
        apply(32'h0000_0000, 1'b0, 31, "R6 zero sign0");
        apply(32'hFFFF_FFFF, 1'b1, 31, "R6 all ones sign1");
        apply(32'hFFFF_FFFE, 1'b1, 31, "R5 bit0 only after invert");
        apply(32'hC000_0000, 1'b1, 2,  "R3 negative 0xC0000000");
        apply(32'h7FFF_FFFF, 1'b1, 0,  "R3 negative top bit clear");
        apply(32'hBFFF_FFFF, 1'b1, 1,  "R3 R4 bit30 clear after invert");
        apply(32'h0001_0000, 1'b0, 15, "R2 bit16");
        apply(32'h0000_8000, 1'b0, 16, "R2 bit15");

        // Every single-bit word under both sign values (R2, R3)
        for (int s = 0; s < 2; s++) begin
            for (int b = 0; b < W; b++) begin
                logic [W-1:0] w;
                w = (32'h1 << b) ^ {W{s[0]}};
                apply(w, s[0], W - 1 - b, s == 0 ? "R2 single bit" : "R3 single bit inverted");
            end
        end

        // Random words of every leading-zero length, both signs (R2, R3)
        for (int rep = 0; rep < 40; rep++) begin
            for (int n = 0; n < W; n++) begin
                logic [W-1:0] x;
                logic s;
                x = ($urandom() >> n) | (32'h8000_0000 >> n);
                s = rep[0];
                apply(s ? ~x : x, s, n, s ? "R3 random negative" : "R2 random positive");
            end
        end

        // Fully random words against the reference count (R2)
        for (int k = 0; k < 2000; k++) begin
            logic [W-1:0] w;
            logic s;
            w = $urandom();
            s = k[0];
            apply(w, s, ref_count(w, s), "R2 random word");
        end

        // R7: output known for a spread of inputs
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            mant = $urandom();
            sgn  = k[1];
            #1;
            n_checks++;
            if ($isunknown(shift)) begin
                n_errors++;
                $display("FAIL R7 actual=%b expected=known", shift);
            end
        end

        // R8: two changes inside one clock period, each seen without an edge
        @(posedge clk);
        #0.5;
        mant = 32'h0010_0000; sgn = 1'b0;
        #0.5;
        expect_val(11, "R8 first change mid-cycle");
        mant = 32'hFFF0_0000; sgn = 1'b1;
        #0.5;
        expect_val(12, "R8 second change same cycle");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(5ns * 100000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R8 watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule